// File: doc/BRIEF.md
# Watchdog and Clock-Loss Supervisor

This block guards a processor subsystem against runaway software and against a failed main clock. A programmable watchdog counts main-clock cycles toward a period picked by a two-bit selector. Unless software performs a two-byte service sequence in time, the watchdog raises a reset request. A second watchdog with a fixed period runs whenever a strap input is high, and it can run alongside the programmable one. Both watchdogs share the same service sequence.

A clock monitor runs from an independent, slower reference clock. It keeps a request/acknowledge handshake going across to the main clock domain and counts reference ticks that pass without an answer. A moderate gap is treated as a slow clock and produces a reset pulse of fixed length. A long gap is treated as an absent clock and holds reset until the main clock answers again. A one-byte control register on a small register bus holds the enables and the period selector. The power-on reset `rst_n` clears everything.

Top module: `cop_clkmon_ctrl`

## Requirements
- R1: After power-on reset, `reset_req` and `cop_flag` are low and the control register (`reg_sel`=0) reads 0x00.
- R2: Control register layout: bits 1:0 select the period, bit 2 enables the programmable watchdog, bit 3 enables the clock monitor and bit 4 is the read-only COP flag. Bits 7:5 always read 0, whatever was written.
- R3: The clock-monitor enable (bit 3) takes the value of every write to the control register.
- R4: Bits 2:0 take effect only on the first control-register write after reset. Later writes leave them unchanged until the next reset.
- R5: With the programmable watchdog enabled and not serviced, timeouts occur every 2^(BASE_LOG2 + STEP_LOG2*sel) main-clock cycles, where sel is bits 1:0.
- R6: Each watchdog timeout drives `reset_req` high for exactly 4 main-clock cycles and sets `cop_flag`.
- R7: Writing 0x55 and then 0xAA to the service register (`reg_sel`=1) restarts both watchdog counters. An 0xAA that does not directly follow 0x55 restarts nothing.
- R8: While `fixed_cop_en` is high, a second watchdog times out every 2^FIXED_LOG2 main-clock cycles, with the same reset pulse as R6.
- R9: With the clock monitor enabled, a gap of SLOW_TH reference cycles without a main-clock answer gives a `reset_req` pulse of exactly 4 reference-clock cycles. A main clock at full speed gives none.
- R10: With the clock monitor enabled, a gap of ABSENT_TH reference cycles holds `reset_req` high until the main clock answers again, and it sets `cop_flag`.
- R11: With the clock-monitor enable clear, a stopped main clock causes no reset request.
- R12: A read of the control register while the COP flag is set clears the flag. Writes do not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, the clock being supervised |
| ref_clk | input | 1 | Independent reference clock, slower than `clk` |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fixed_cop_en | input | 1 | Strap that runs the fixed-period watchdog |
| reg_sel | input | 1 | Register select: 0 control, 1 service |
| wr_en | input | 1 | Write strobe, sampled on `clk` |
| rd_en | input | 1 | Read strobe, sampled on `clk` (clears the flag on a control read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (service reads 0) |
| reset_req | output | 1 | Reset request from either watchdog or the clock monitor |
| cop_flag | output | 1 | Sticky flag for a watchdog timeout or an absent clock |

## Verification
Each of the four period codes is left unserviced, and the spacing between successive reset pulses is measured, so a wrong shift or an off-by-one in the counter shows up as an exact cycle difference. The service path is driven with a correct 0x55/0xAA rhythm and with scrambled orders (a bare 0xAA, and 0x55 broken by another byte). This tells a true restart apart from one that fires on any write. The clock monitor sees a full-speed main clock, a main clock slowed well past the slow threshold and a stopped main clock. These three separate the fixed-length pulse from the held reset, and the enabled monitor from the disabled one.

// File: rtl/cop_pkg.sv
package cop_pkg;
  // register select codes
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_SVC  = 1'b1;

  // service sequence bytes
  localparam logic [7:0] SVC_ARM  = 8'h55;
  localparam logic [7:0] SVC_FIRE = 8'hAA;

  // control register bit positions
  localparam int B_TSEL = 0;   // two bits: period select
  localparam int B_PCOP = 2;
  localparam int B_CME  = 3;
  localparam int B_FLAG = 4;

  // reset pulse shaping
  localparam int PULSE_LEN = 4;
  localparam int PULSE_W   = 3;

  typedef struct packed {
    logic       pcop_en;
    logic [1:0] tsel;
  } wd_cfg_t;
endpackage

// File: rtl/cop_sync.sv
module cop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= d_i;
      end
      assign q_o = q;
    end else begin : g_multi
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cop_regs.sv
module cop_regs
  import cop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  input  logic       flag_set_i,
  output logic [7:0] rdata_o,
  output logic       cme_o,
  output wd_cfg_t    cfg_o,
  output logic       kick_o,
  output logic       flag_o
);
  logic    cme_q, cme_d;
  wd_cfg_t cfg_q, cfg_d;
  logic    lock_q, lock_d;
  logic    armed_q, armed_d;
  logic    kick_q, kick_d;
  logic    flag_q, flag_d;
  logic    wr_ctrl, wr_svc, rd_ctrl;

  always_comb begin
    wr_ctrl = wr_en_i && (sel_i == SEL_CTRL);
    wr_svc  = wr_en_i && (sel_i == SEL_SVC);
    rd_ctrl = rd_en_i && (sel_i == SEL_CTRL);

    cme_d  = cme_q;
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (wr_ctrl) begin
      cme_d  = wdata_i[B_CME];
      lock_d = 1'b1;
      if (!lock_q) begin
        cfg_d.pcop_en = wdata_i[B_PCOP];
        cfg_d.tsel    = wdata_i[B_TSEL +: 2];
      end
    end

    armed_d = armed_q;
    kick_d  = 1'b0;
    if (wr_svc) begin
      if (wdata_i == SVC_ARM) begin
        armed_d = 1'b1;
      end else begin
        armed_d = 1'b0;
        kick_d  = (wdata_i == SVC_FIRE) && armed_q;
      end
    end

    flag_d = flag_q;
    if (flag_set_i)            flag_d = 1'b1;
    else if (rd_ctrl && flag_q) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cme_q   <= 1'b0;
      cfg_q   <= '0;
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
      kick_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      cme_q   <= cme_d;
      cfg_q   <= cfg_d;
      lock_q  <= lock_d;
      armed_q <= armed_d;
      kick_q  <= kick_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CTRL) begin
      rdata_o[B_TSEL +: 2] = cfg_q.tsel;
      rdata_o[B_PCOP]      = cfg_q.pcop_en;
      rdata_o[B_CME]       = cme_q;
      rdata_o[B_FLAG]      = flag_q;
    end
  end

  assign cme_o  = cme_q;
  assign cfg_o  = cfg_q;
  assign kick_o = kick_q;
  assign flag_o = flag_q;

  // R4: once the first write has landed, the watchdog fields never move
  a_r4_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(cfg_q));

  // R12: a control read of a set flag clears it unless a new event arrives
  a_r12_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && flag_q && !flag_set_i) |=> !flag_q);

  // R7: a restart only follows an armed state
  a_r7_kick_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_q |-> $past(armed_q));
endmodule

// File: rtl/cop_wdog.sv
module cop_wdog #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          kick_i,
  input  logic [CW-1:0] last_i,
  output logic          tout_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tout_o = en_i && (cnt_q == last_i);
    if (!en_i || kick_i || tout_o) cnt_d = '0;
    else                           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: the running count never passes the selected terminal value
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= last_i));
endmodule

// File: rtl/cop_clkmon.sv
module cop_clkmon
  import cop_pkg::*;
#(
  parameter int SLOW_TH   = 64,
  parameter int ABSENT_TH = 512
) (
  input  logic ref_clk_i,
  input  logic ref_rst_ni,
  input  logic cme_i,
  input  logic pong_i,
  output logic ping_o,
  output logic slow_rst_o,
  output logic absent_o
);
  localparam int GW = $clog2(ABSENT_TH + 1);
  localparam logic [GW-1:0] SLOW_LAST = GW'(SLOW_TH - 1);
  localparam logic [GW-1:0] ABS_LAST  = GW'(ABSENT_TH - 1);

  logic               cme_s, pong_s, match;
  logic               ping_q, ping_d;
  logic [GW-1:0]      gap_q, gap_d;
  logic               absent_q, absent_d;
  logic [PULSE_W-1:0] pulse_q, pulse_d;

  cop_sync #(.STAGES(2)) u_cme_sync (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_ni), .d_i(cme_i), .q_o(cme_s));
  cop_sync #(.STAGES(2)) u_pong_sync (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_ni), .d_i(pong_i), .q_o(pong_s));

  assign match = (pong_s == ping_q);

  always_comb begin
    ping_d   = ping_q;
    gap_d    = gap_q;
    absent_d = absent_q;
    pulse_d  = (pulse_q != '0) ? pulse_q - PULSE_W'(1) : '0;
    if (match) begin
      ping_d   = ~ping_q;
      gap_d    = '0;
      absent_d = 1'b0;
    end else if (!cme_s) begin
      gap_d    = '0;
      absent_d = 1'b0;
    end else if (gap_q < ABS_LAST) begin
      gap_d = gap_q + GW'(1);
      if (gap_q == SLOW_LAST) pulse_d = PULSE_W'(PULSE_LEN);
    end else begin
      absent_d = 1'b1;
    end
  end

  always_ff @(posedge ref_clk_i or negedge ref_rst_ni) begin
    if (!ref_rst_ni) begin
      ping_q   <= 1'b0;
      gap_q    <= '0;
      absent_q <= 1'b0;
      pulse_q  <= '0;
    end else begin
      ping_q   <= ping_d;
      gap_q    <= gap_d;
      absent_q <= absent_d;
      pulse_q  <= pulse_d;
    end
  end

  assign ping_o     = ping_q;
  assign slow_rst_o = (pulse_q != '0);
  assign absent_o   = absent_q;

  // R9: the slow-clock pulse starts at full length and never exceeds it
  a_r9_pulse_max: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    pulse_q <= PULSE_W'(PULSE_LEN));
  a_r9_pulse_start: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    $rose(slow_rst_o) |-> (pulse_q == PULSE_W'(PULSE_LEN)));

  // R10: absent state holds until the main clock answers
  a_r10_absent_hold: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    (absent_q && cme_s && !match) |=> absent_q);

  // R11: disabled monitor never holds the absent state
  a_r11_quiet_off: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    !cme_s |=> !absent_q);
endmodule

// File: rtl/cop_clkmon_ctrl.sv
module cop_clkmon_ctrl
  import cop_pkg::*;
#(
  parameter int BASE_LOG2  = 15,
  parameter int STEP_LOG2  = 2,
  parameter int FIXED_LOG2 = 21,
  parameter int SLOW_TH    = 64,
  parameter int ABSENT_TH  = 512
) (
  input  logic       clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       fixed_cop_en,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       reset_req,
  output logic       cop_flag
);
  localparam int CW_P = BASE_LOG2 + 3 * STEP_LOG2;

  logic               rst_main_n, rst_ref_n;
  logic               cme, kick, flag;
  wd_cfg_t            cfg;
  logic [CW_P-1:0]    last_p;
  logic [63:0]        one_sh;
  logic               tout_p, tout_f, trigger;
  logic [PULSE_W-1:0] rst_cnt_q, rst_cnt_d;
  logic               ping, pong;
  logic               slow_rst, absent, absent_m, absent_m_q, absent_rise;

  // reset release synchronised in each clock domain
  cop_sync #(.STAGES(2)) u_rst_main (
    .clk_i(clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(rst_main_n));
  cop_sync #(.STAGES(2)) u_rst_ref (
    .clk_i(ref_clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(rst_ref_n));

  cop_regs u_regs (
    .clk_i(clk), .rst_ni(rst_main_n), .sel_i(reg_sel), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .flag_set_i(trigger | absent_rise),
    .rdata_o(rdata), .cme_o(cme), .cfg_o(cfg), .kick_o(kick), .flag_o(flag));

  always_comb begin
    one_sh = 64'd1 << (BASE_LOG2 + STEP_LOG2 * int'(cfg.tsel));
    last_p = CW_P'(one_sh - 64'd1);
  end

  cop_wdog #(.CW(CW_P)) u_wdog_prog (
    .clk_i(clk), .rst_ni(rst_main_n), .en_i(cfg.pcop_en), .kick_i(kick),
    .last_i(last_p), .tout_o(tout_p));

  cop_wdog #(.CW(FIXED_LOG2)) u_wdog_fixed (
    .clk_i(clk), .rst_ni(rst_main_n), .en_i(fixed_cop_en), .kick_i(kick),
    .last_i({FIXED_LOG2{1'b1}}), .tout_o(tout_f));

  // main-domain echo of the monitor's handshake
  cop_sync #(.STAGES(2)) u_ping_sync (
    .clk_i(clk), .rst_ni(rst_main_n), .d_i(ping), .q_o(pong));

  cop_clkmon #(.SLOW_TH(SLOW_TH), .ABSENT_TH(ABSENT_TH)) u_clkmon (
    .ref_clk_i(ref_clk), .ref_rst_ni(rst_ref_n), .cme_i(cme), .pong_i(pong),
    .ping_o(ping), .slow_rst_o(slow_rst), .absent_o(absent));

  cop_sync #(.STAGES(2)) u_absent_sync (
    .clk_i(clk), .rst_ni(rst_main_n), .d_i(absent), .q_o(absent_m));

  // watchdog reset pulse shaping
  always_comb begin
    trigger     = tout_p | tout_f;
    absent_rise = absent_m && !absent_m_q;
    if (trigger)                rst_cnt_d = PULSE_W'(PULSE_LEN);
    else if (rst_cnt_q != '0)   rst_cnt_d = rst_cnt_q - PULSE_W'(1);
    else                        rst_cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_main_n) begin
    if (!rst_main_n) begin
      rst_cnt_q  <= '0;
      absent_m_q <= 1'b0;
    end else begin
      rst_cnt_q  <= rst_cnt_d;
      absent_m_q <= absent_m;
    end
  end

  assign reset_req = (rst_cnt_q != '0) | slow_rst | absent;
  assign cop_flag  = flag;

  // R6: the pulse counts down one per cycle until retriggered
  a_r6_pulse_count: assert property (@(posedge clk) disable iff (!rst_main_n)
    (rst_cnt_q != '0 && !trigger) |=> (rst_cnt_q == $past(rst_cnt_q) - PULSE_W'(1)));

  // R6: every timeout leaves the flag set
  a_r6_flag_on_timeout: assert property (@(posedge clk) disable iff (!rst_main_n)
    trigger |=> cop_flag);
endmodule

// File: tb/cop_clkmon_ctrl_bench.sv
module cop_clkmon_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SLOW_TH    = 8;
  localparam int ABSENT_TH  = 40;
  localparam int BASE_LOG2  = 4;
  localparam int STEP_LOG2  = 2;
  localparam int FIXED_LOG2 = 9;

  logic       clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic       fixed_cop_en = 1'b0, reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       reset_req, cop_flag;

  realtime half_main = 2.5;
  bit      clk_run = 1'b1;
  int      checks = 0, fails = 0, main_hits = 0, ref_hits = 0;

  cop_clkmon_ctrl #(
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .FIXED_LOG2(FIXED_LOG2),
    .SLOW_TH(SLOW_TH), .ABSENT_TH(ABSENT_TH)
  ) u_cop_clkmon_ctrl (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .fixed_cop_en(fixed_cop_en),
    .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .reset_req(reset_req), .cop_flag(cop_flag));

  always begin
    if (clk_run) #(half_main) clk = ~clk;
    else         #1;
  end
  always #20 ref_clk = ~ref_clk;

  always @(negedge clk)     if (reset_req === 1'b1) main_hits++;
  always @(negedge ref_clk) if (reset_req === 1'b1) ref_hits++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic por();
    rst_n = 1'b0; clk_run = 1'b1; half_main = 2.5; fixed_cop_en = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge ref_clk);
    rst_n = 1'b1;
    repeat (6) @(posedge ref_clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_main(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_ref(input int n);  repeat (n) @(negedge ref_clk); endtask

  // negedges of clk until the next rising edge of reset_req
  task automatic next_rise(output int n);
    logic p;
    n = 0; p = reset_req;
    do begin
      @(negedge clk); n++;
      if (reset_req && !p) break;
      p = reset_req;
    end while (n < 5000);
  endtask

  task automatic width_main(output int w);
    w = 1;
    while (w < 50) begin
      @(negedge clk);
      if (!reset_req) break;
      w++;
    end
  endtask

  task automatic ref_pulse_width(output int w);
    logic p; int g;
    g = 0; w = 0; p = reset_req;
    do begin
      @(negedge ref_clk); g++;
      if (reset_req && !p) break;
      p = reset_req;
    end while (g < 400);
    if (reset_req) begin
      w = 1;
      while (w < 50) begin
        @(negedge ref_clk);
        if (!reset_req) break;
        w++;
      end
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    por();
    check("R1 reset_req", reset_req, 0);
    check("R1 cop_flag", cop_flag, 0);
    rd(1'b0, v);
    check("R1 control", v, 8'h00);
  endtask

  task automatic t_write_rules();
    logic [7:0] v;
    por();
    wr(1'b0, 8'hE6);
    rd(1'b0, v);
    check("R2 upper bits zero", v, 8'h06);
    wr(1'b0, 8'h09);
    rd(1'b0, v);
    check("R3/R4 cme set, cfg locked", v, 8'h0E);
    wr(1'b0, 8'h00);
    rd(1'b0, v);
    check("R3/R4 cme clear, cfg locked", v, 8'h06);
  endtask

  task automatic t_period();
    int n, w;
    for (int ts = 0; ts < 4; ts++) begin
      por();
      wr(1'b0, 8'h04 | 8'(ts));
      next_rise(n);
      next_rise(n);
      check("R5 period", n, 1 << (BASE_LOG2 + STEP_LOG2 * ts));
      width_main(w);
      check("R6 pulse width", w, 4);
      check("R6 flag set", cop_flag, 1);
    end
  endtask

  task automatic t_flag();
    logic [7:0] v;
    por();
    wr(1'b0, 8'h07);
    wait_main(1030);
    check("R12 flag after timeout", cop_flag, 1);
    wr(1'b0, 8'h00);
    check("R12 write keeps flag", cop_flag, 1);
    rd(1'b0, v);
    check("R12 flag visible in read", (v >> 4) & 8'h01, 1);
    check("R12 read clears flag", cop_flag, 0);
  endtask

  task automatic t_service();
    int h0;
    por();
    wr(1'b0, 8'h04);
    h0 = main_hits;
    repeat (8) begin
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      wait_main(4);
    end
    check("R7 serviced, no reset", main_hits - h0, 0);
    h0 = main_hits;
    repeat (4) begin
      wr(1'b1, 8'hAA);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h33);
      wr(1'b1, 8'hAA);
      wait_main(2);
    end
    check("R7 bad order still times out", (main_hits > h0) ? 1 : 0, 1);
  endtask

  task automatic t_fixed();
    int n, w;
    por();
    fixed_cop_en = 1'b1;
    next_rise(n);
    next_rise(n);
    check("R8 fixed period", n, 1 << FIXED_LOG2);
    width_main(w);
    check("R8 fixed pulse width", w, 4);
    fixed_cop_en = 1'b0;
  endtask

  task automatic t_slow();
    int h, w;
    por();
    wr(1'b0, 8'h08);
    h = ref_hits;
    wait_ref(60);
    check("R9 fast clock gives no reset", ref_hits - h, 0);
    half_main = 200.0;
    ref_pulse_width(w);
    check("R9 slow pulse width", w, 4);
    half_main = 2.5;
    wait_ref(20);
  endtask

  task automatic t_absent();
    logic [7:0] v;
    por();
    wr(1'b0, 8'h08);
    @(negedge clk); clk_run = 1'b0;
    wait_ref(80);
    check("R10 reset held", reset_req, 1);
    wait_ref(40);
    check("R10 reset still held", reset_req, 1);
    clk_run = 1'b1;
    wait_ref(12);
    check("R10 reset released", reset_req, 0);
    @(negedge clk);
    check("R10 flag set", cop_flag, 1);
    rd(1'b0, v);
    check("R12 flag bit read", (v >> 4) & 8'h01, 1);
    check("R12 cleared by read", cop_flag, 0);
  endtask

  task automatic t_cme_off();
    int h;
    por();
    @(negedge clk); clk_run = 1'b0;
    h = ref_hits;
    wait_ref(80);
    check("R11 disabled monitor quiet", ref_hits - h, 0);
    clk_run = 1'b1;
    wait_ref(10);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_write_rules();
    t_period();
    t_flag();
    t_service();
    t_fixed();
    t_slow();
    t_absent();
    t_cme_off();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule